// File: doc/BRIEF.md
# TLB Replacement Index Generator

This block supplies a pseudo-random TLB entry index for replacement on a refill. The lowest entries, up to a programmable count, are wired, and the block never returns one of them. It keeps a 32-bit linear congruential state. Each accepted request moves the state one step, takes the upper half of the new state and reduces it into the unwired range of entries.

A requester pulses `req_i` while `busy_o` is low, with the current wired count on `wired_i`. A sequential restoring divider finds the remainder at one bit per cycle. Then `valid_o` rises and `idx_o` holds the chosen entry until the next accepted request. If the wired count covers the whole TLB, the block skips the divider and returns the top entry on the next cycle.

Top module: `tlb_rand_idx`

## Requirements
- R1: After reset, `valid_o`, `busy_o` and `idx_o` are 0, and the internal state is 0.
- R2: Each accepted request, that is `req_i` high while `busy_o` is low, advances the state once as state = state * 314159 + 1, modulo 2^32.
- R3: When the captured wired count w is below ENTRIES, the result is (s[31:16] mod (ENTRIES - w)) + w, where s is the state after the advance for that request.
- R4: When w is below ENTRIES, every valid result lies in [w, ENTRIES-1].
- R5: When w is below ENTRIES, `busy_o` is high from the edge that accepts the request until the result edge. `valid_o` rises exactly 16 clock edges after the accepting edge.
- R6: When w >= ENTRIES, `idx_o` is ENTRIES-1 and `valid_o` is high one edge after acceptance, and `busy_o` stays low. The state still advances.
- R7: A request made while `busy_o` is high is ignored. It does not advance the state and does not change the pending result.
- R8: `valid_o` falls on the accepting edge of a divider request. A valid result stays stable until the next accepted request.
- R9: `wired_i` is sampled only on the accepting edge. Changes to it during a computation have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe; advances the generator when not busy |
| wired_i | input | 6 | Number of wired (protected) low entries |
| idx_o | output | $clog2(ENTRIES) | Selected entry index |
| valid_o | output | 1 | `idx_o` holds a finished result |
| busy_o | output | 1 | Divider running; requests are ignored |

## Verification
A corrupted congruential state shows up at the next result as an index that differs from the arithmetic model. Every later result also differs, because the error carries forward, so one wrong step is caught within one request of about 16 cycles. A divider fault appears as an index outside [w, ENTRIES-1], a wrong remainder or a latency other than 16 edges, all of which are visible at the first `valid_o`. A leak of requests or wired changes made during a computation shifts the whole following sequence, and the bench sees this on the next result.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
  localparam int unsigned LCG_W   = 32;
  localparam int unsigned SEL_W   = 16;
  localparam logic [LCG_W-1:0] LCG_MUL = 32'd314159;
  localparam logic [LCG_W-1:0] LCG_INC = 32'd1;

  function automatic logic [LCG_W-1:0] lcg_next(input logic [LCG_W-1:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction
endpackage

// File: rtl/tlb_rand_lcg.sv
module tlb_rand_lcg
  import tlb_rand_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEL_W-1:0] sel_o   // upper bits of the next state
);
  logic [LCG_W-1:0] state_q, state_d;

  assign state_d = lcg_next(state_q);
  assign sel_o   = state_d[LCG_W-1 -: SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (adv_i) state_q <= state_d;
  end

  // R2 R7
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));
endmodule

// File: rtl/tlb_rand_div.sv
module tlb_rand_div #(
  parameter int unsigned DVD_W = 16,
  parameter int unsigned DVS_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVS_W-1:0] rem_o
);
  localparam int unsigned CNT_W = $clog2(DVD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DVD_W - 1);

  logic [DVD_W-1:0] dvd_q;
  logic [DVS_W-1:0] dvs_q, rem_q, rem_d;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DVS_W:0]   shifted, diff;

  // one restoring step per cycle
  always_comb begin
    shifted = {rem_q, dvd_q[DVD_W-1]};
    diff    = shifted - {1'b0, dvs_q};
    rem_d   = diff[DVS_W] ? shifted[DVS_W-1:0] : diff[DVS_W-1:0];
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_LAST);
  assign rem_o  = rem_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      dvd_q  <= dividend_i;
      dvs_q  <= divisor_i;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      dvd_q  <= {dvd_q[DVD_W-2:0], 1'b0};
      rem_q  <= rem_d;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
    end
  end

  // R3
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q < dvs_q);
  // R5
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
  import tlb_rand_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned WIRED_W = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [WIRED_W-1:0]         wired_i,
  output logic [$clog2(ENTRIES)-1:0] idx_o,
  output logic                       valid_o,
  output logic                       busy_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned CW    = WIRED_W + 1;
  localparam logic [CW-1:0] ENT = CW'(ENTRIES);

  logic             accept, ovf, div_busy, div_done;
  logic [CW-1:0]    wired_ext, wired_q, rem;
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;

  assign wired_ext = CW'(wired_i);
  assign accept    = req_i && !div_busy;
  assign ovf       = wired_ext >= ENT;

  tlb_rand_lcg u_lcg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .sel_o (sel)
  );

  tlb_rand_div #(.DVD_W(SEL_W), .DVS_W(CW)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept && !ovf),
    .dividend_i(sel),
    .divisor_i (ENT - wired_ext),
    .busy_o    (div_busy),
    .done_o    (div_done),
    .rem_o     (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wired_q <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (accept) begin
      wired_q <= wired_ext;
      if (ovf) begin
        idx_q   <= IDX_W'(ENTRIES - 1);
        valid_q <= 1'b1;
      end else begin
        valid_q <= 1'b0;
      end
    end else if (div_done) begin
      idx_q   <= IDX_W'(rem + wired_q);
      valid_q <= 1'b1;
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;
  assign busy_o  = div_busy;

  // R4
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && wired_q < ENT) |-> (CW'(idx_q) >= wired_q && CW'(idx_q) < ENT));
  // R6
  ovf_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && wired_q >= ENT) |-> idx_q == IDX_W'(ENTRIES - 1));
  // R5
  busy_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> !valid_q);
  // R8
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !req_i) |=> (valid_q && $stable(idx_q)));
  // R9
  wired_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |=> $stable(wired_q));
endmodule

// File: tb/tlb_rand_idx_tb.sv
`timescale 1ns/1ps
module tlb_rand_idx_tb_top;
  localparam int unsigned E     = 16;
  localparam int unsigned IDX_W = $clog2(E);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic [5:0]       wired = '0;
  logic [IDX_W-1:0] idx;
  logic             valid, busy;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  tlb_rand_idx #(.ENTRIES(E), .WIRED_W(6)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wired_i(wired),
    .idx_o(idx), .valid_o(valid), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // one request; noise=1 adds an ignored request and a wired change mid-run
  task automatic run_req(input int w, input bit noise);
    int exp, lat;
    @(negedge clk);
    wired = 6'(w);
    req   = 1'b1;
    @(posedge clk); #1;
    req   = 1'b0;
    model = model * 32'd314159 + 32'd1;  // R2
    if (w >= E) begin
      chk(valid == 1'b1, "R6 valid", int'(valid), 1);
      chk(busy == 1'b0, "R6 busy", int'(busy), 0);
      chk(int'(idx) == E - 1, "R6 idx", int'(idx), E - 1);
    end else begin
      exp = int'(model[31:16]) % (E - w) + w;
      chk(valid == 1'b0 && busy == 1'b1, "R8 valid drop", int'(valid), 0);
      lat = 0;
      while (!valid && lat < 40) begin
        if (noise && lat == 4) begin
          req   = 1'b1;               // R7 ignored
          wired = 6'((w + 3) % 64);   // R9 ignored
        end
        @(posedge clk); #1;
        req = 1'b0;
        lat++;
        if (!valid) chk(busy == 1'b1, "R5 busy", int'(busy), 1);
      end
      chk(lat == 16, "R5 latency", lat, 16);
      chk(busy == 1'b0, "R5 busy end", int'(busy), 0);
      chk(int'(idx) == exp, noise ? "R7/R9 idx" : "R3 idx", int'(idx), exp);
      chk(int'(idx) >= w && int'(idx) <= E - 1, "R4 range", int'(idx), w);
      repeat (3) @(posedge clk);
      #1;
      chk(valid == 1'b1 && int'(idx) == exp, "R8 hold", int'(idx), exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(idx == '0, "R1 idx", int'(idx), 0);
    rst_n = 1'b1;
    // first result uses state 1 derived from zero seed (R1)
    run_req(0, 1'b0);
    for (int w = 0; w <= 20; w++) begin
      for (int k = 0; k < 3; k++) run_req(w, k == 1);
    end
    for (int k = 0; k < 40; k++) run_req(k % 16, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule